// File: doc/BRIEF.md
# Set/Clear/Toggle Alias Register Bank

This block is a bank of 32-bit control registers on a simple word bus with separate read and write ports. Part of the bank consists of aliased groups. Each group owns four consecutive word slots. The first slot is the register itself. The other three slots change that register in one bus cycle: one sets bits, one clears bits and one inverts bits, according to the ones in the write data. A read through any slot of a group returns the register. Software can therefore change single fields of a shared register without a read-modify-write sequence.

The rest of the bank is plain registers, which a write replaces in full. Seven of the groups model PLL control words. Their lock flag is forced to one at reset, so every PLL reports as locked. Two more groups model fractional-divider words. Accesses to a misaligned or unmapped address have no effect on any register and raise an error flag.

Top module: `alias_regbank`

## Requirements
- R1: While reset is held and after it is released, `rd_data_o` and `err_o` are 0. Every register takes its reset value. Some examples: the system PLL group reads 0x80013001, the second fractional group reads 0x1018101B, the first fractional group reads 0x1311100C, and the plain register at byte address 0x94 reads 0x00000012.
- R2: Group g (0 to 8) occupies byte addresses 16g+4k, where k is the slot (0 to 3). A write to slot 0 replaces the group register with the write data.
- R3: A write to slot 1 ORs the write data into the group register.
- R4: A write to slot 2 clears the group register bits that are one in the write data.
- R5: A write to slot 3 XORs the write data into the group register.
- R6: A read of slot 1, 2 or 3 returns the current group register.
- R7: Reset sets bit 31 (the lock flag) in groups 0 to 6. Groups 7 and 8 keep their reset value as listed, with bit 31 clear in group 7. A later reset restores the flag after software has cleared it.
- R8: The six plain registers sit at byte addresses 0x90 to 0xA4. A write replaces a plain register in full, and a read returns it.
- R9: An access is bad if its address has bits [1:0] not equal to zero, or if its byte address is 0xA8 or above. A bad write changes no register. A bad read returns 0. `err_o` is high in the cycle after a bad access and low in the cycle after a good access or no access.
- R10: `rd_data_o` is updated one cycle after `rd_en_i` and holds its value while no read is issued. A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 8 | Read byte address |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid one cycle after the request |
| err_o | output | 1 | Pulse for a misaligned or unmapped access |

## Verification
The assertions assume that every address on the ports is a full 8-bit value. They also assume that the data ports carry no unknown bits while a request is raised. The bench drives both requests and all address and data lines from one negative clock edge to the next, and it parks every input at zero between operations. The same-cycle check of R10 raises both requests together. This stays inside those assumptions because the two ports are decoded independently.

// File: rtl/alias_regbank.sv
module alias_regbank #(
  parameter int DW       = 32,
  parameter int ADDR_W   = 8,
  parameter int N_ALIAS  = 9,
  parameter int N_PLL    = 7,
  parameter int N_PLAIN  = 6,
  parameter int LOCK_BIT = 31,
  parameter logic [N_ALIAS*DW-1:0] GRP_RST = {
    32'h1018101B, 32'h1311100C, 32'h00011001, 32'h0001100C, 32'h00011006,
    32'h00013001, 32'h00012000, 32'h00012000, 32'h00013063},
  parameter logic [N_PLAIN*DW-1:0] PLN_RST = {
    32'h10A24447, 32'h05F5E100, 32'h2964619C, 32'h05F5E100, 32'h00000012,
    32'h00000000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              err_o
);
  localparam int IDX_W      = ADDR_W - 2;
  localparam int GW         = IDX_W - 2;
  localparam int PLAIN_BASE = 4 * N_ALIAS;
  localparam int N_SLOTS    = PLAIN_BASE + N_PLAIN;
  localparam logic [DW-1:0] LOCK_MASK = {{(DW-1){1'b0}}, 1'b1} << LOCK_BIT;

  logic [N_ALIAS-1:0][DW-1:0] grp_q;
  logic [N_PLAIN-1:0][DW-1:0] pln_q;
  logic [DW-1:0]              rd_val;

  wire [IDX_W-1:0] widx  = wr_addr_i[ADDR_W-1:2];
  wire [IDX_W-1:0] ridx  = rd_addr_i[ADDR_W-1:2];
  wire             wr_ok = (wr_addr_i[1:0] == 2'b00) && (widx < IDX_W'(N_SLOTS));
  wire             rd_ok = (rd_addr_i[1:0] == 2'b00) && (ridx < IDX_W'(N_SLOTS));
  wire             wr_go = wr_en_i && wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < N_ALIAS; g++)
        grp_q[g] <= GRP_RST[g*DW +: DW] | ((g < N_PLL) ? LOCK_MASK : '0);
    end else if (wr_go) begin
      for (int g = 0; g < N_ALIAS; g++) begin
        if (widx[IDX_W-1:2] == GW'(g)) begin
          case (widx[1:0])
            2'd0:    grp_q[g] <= wr_data_i;
            2'd1:    grp_q[g] <= grp_q[g] | wr_data_i;
            2'd2:    grp_q[g] <= grp_q[g] & ~wr_data_i;
            default: grp_q[g] <= grp_q[g] ^ wr_data_i;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N_PLAIN; p++)
        pln_q[p] <= PLN_RST[p*DW +: DW];
    end else if (wr_go) begin
      for (int p = 0; p < N_PLAIN; p++)
        if (widx == IDX_W'(PLAIN_BASE + p)) pln_q[p] <= wr_data_i;
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd_ok) begin
      for (int g = 0; g < N_ALIAS; g++)
        if (ridx[IDX_W-1:2] == GW'(g)) rd_val = grp_q[g];
      for (int p = 0; p < N_PLAIN; p++)
        if (ridx == IDX_W'(PLAIN_BASE + p)) rd_val = pln_q[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      err_o     <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_val;
      err_o <= (rd_en_i && !rd_ok) || (wr_en_i && !wr_ok);
    end
  end
endmodule

// File: rtl/alias_regbank_chk.sv
module alias_regbank_chk #(
  parameter int DW       = 32,
  parameter int ADDR_W   = 8,
  parameter int N_ALIAS  = 9,
  parameter int N_PLL    = 7,
  parameter int N_PLAIN  = 6,
  parameter int LOCK_BIT = 31,
  parameter logic [N_ALIAS*DW-1:0] GRP_RST = '0
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       rd_en_i,
  input logic [ADDR_W-1:0]          rd_addr_i,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [DW-1:0]              wr_data_i,
  input logic [DW-1:0]              rd_data_o,
  input logic                       err_o,
  input logic [N_ALIAS-1:0][DW-1:0] grp_q,
  input logic [N_PLAIN-1:0][DW-1:0] pln_q
);
  localparam int END_BYTE = 4 * (4 * N_ALIAS + N_PLAIN);

  wire rd_bad = (rd_addr_i[1:0] != 2'b00) || (int'(rd_addr_i) >= END_BYTE);
  wire wr_bad = (wr_addr_i[1:0] != 2'b00) || (int'(wr_addr_i) >= END_BYTE);

  for (genvar g = 0; g < N_ALIAS; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] B = ADDR_W'(16 * g);
    localparam logic [DW-1:0] EXP_RST = GRP_RST[g*DW +: DW] |
      ((g < N_PLL) ? ({{(DW-1){1'b0}}, 1'b1} << LOCK_BIT) : '0);

    assert_reset_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(rst_ni) |-> grp_q[g] == EXP_RST);
    assert_base_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == B) |=> grp_q[g] == $past(wr_data_i));
    assert_set_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == B + 4) |=> grp_q[g] == ($past(grp_q[g]) | $past(wr_data_i)));
    assert_clr_alias_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == B + 8) |=> grp_q[g] == ($past(grp_q[g]) & ~$past(wr_data_i)));
    assert_tog_alias_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == B + 12) |=> grp_q[g] == ($past(grp_q[g]) ^ $past(wr_data_i)));
    assert_alias_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && rd_addr_i[ADDR_W-1:4] == B[ADDR_W-1:4] && rd_addr_i[1:0] == 2'b00)
      |=> rd_data_o == $past(grp_q[g]));
  end

  for (genvar p = 0; p < N_PLAIN; p++) begin : g_pln
    localparam logic [ADDR_W-1:0] A = ADDR_W'(16 * N_ALIAS + 4 * p);
    assert_plain_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == A) |=> pln_q[p] == $past(wr_data_i));
  end

  assert_bad_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_bad) |=> ($stable(grp_q) && $stable(pln_q)));
  assert_bad_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_bad) |=> rd_data_o == '0);
  assert_err_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i && rd_bad) || (wr_en_i && wr_bad)) |=> err_o);
  assert_err_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((rd_en_i && rd_bad) || (wr_en_i && wr_bad)) |=> !err_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind alias_regbank alias_regbank_chk #(
  .DW(DW), .ADDR_W(ADDR_W), .N_ALIAS(N_ALIAS), .N_PLL(N_PLL),
  .N_PLAIN(N_PLAIN), .LOCK_BIT(LOCK_BIT), .GRP_RST(GRP_RST)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .err_o(err_o), .grp_q(grp_q), .pln_q(pln_q)
);

// File: tb/test_alias_regbank.sv
`timescale 1ns/1ps
module test_alias_regbank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alias_regbank i_alias_regbank (
    .clk_i(clk), .rst_ni(rst_ni), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .err_o(err)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h30, 32'h0,        32'h80013001, 1'b0, 4'd1},  // R1 R7 system PLL
    '{1'b0, 8'h3C, 32'h0,        32'h80013001, 1'b0, 4'd6},  // R6 toggle slot read
    '{1'b0, 8'h94, 32'h0,        32'h00000012, 1'b0, 4'd1},  // R1 plain reset
    '{1'b0, 8'h80, 32'h0,        32'h1018101B, 1'b0, 4'd7},  // R7 no lock on group 8
    '{1'b0, 8'h70, 32'h0,        32'h1311100C, 1'b0, 4'd7},  // R7 no lock on group 7
    '{1'b0, 8'h00, 32'h0,        32'h80013063, 1'b0, 4'd7},  // R7 group 0 locked
    '{1'b1, 8'h34, 32'h00000F00, 32'h0,        1'b0, 4'd3},  // R3 set
    '{1'b0, 8'h30, 32'h0,        32'h80013F01, 1'b0, 4'd3},
    '{1'b1, 8'h38, 32'h80000001, 32'h0,        1'b0, 4'd4},  // R4 clear
    '{1'b0, 8'h34, 32'h0,        32'h00013F00, 1'b0, 4'd4},
    '{1'b1, 8'h3C, 32'h0001FFFF, 32'h0,        1'b0, 4'd5},  // R5 toggle
    '{1'b0, 8'h38, 32'h0,        32'h0000C0FF, 1'b0, 4'd5},
    '{1'b1, 8'h30, 32'hDEADBEEF, 32'h0,        1'b0, 4'd2},  // R2 base write
    '{1'b0, 8'h30, 32'h0,        32'hDEADBEEF, 1'b0, 4'd2},
    '{1'b1, 8'h94, 32'h00000034, 32'h0,        1'b0, 4'd8},  // R8 plain write
    '{1'b0, 8'h94, 32'h0,        32'h00000034, 1'b0, 4'd8},
    '{1'b1, 8'h98, 32'h12345678, 32'h0,        1'b0, 4'd8},
    '{1'b0, 8'h98, 32'h0,        32'h12345678, 1'b0, 4'd8},
    '{1'b1, 8'hA8, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd9},  // R9 unmapped write
    '{1'b0, 8'hA8, 32'h0,        32'h0,        1'b1, 4'd9},  // R9 unmapped read
    '{1'b0, 8'hFC, 32'h0,        32'h0,        1'b1, 4'd9},
    '{1'b1, 8'h31, 32'h0,        32'h0,        1'b1, 4'd9},  // R9 misaligned write
    '{1'b0, 8'h30, 32'h0,        32'hDEADBEEF, 1'b0, 4'd9},
    '{1'b0, 8'h32, 32'h0,        32'h0,        1'b1, 4'd9},  // R9 misaligned read
    '{1'b0, 8'hA4, 32'h0,        32'h10A24447, 1'b0, 4'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [7:0] a, input logic [31:0] d);
    if (w) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    else begin rd_en = 1'b1; rd_addr = a; end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 32'h0);
    chk("R1 err in reset", {31'b0, err}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 err after reset", {31'b0, err}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].wr, VEC[i].addr, VEC[i].data);
      chk($sformatf("R%0d err vec %0d", VEC[i].req, i), {31'b0, err}, {31'b0, VEC[i].err});
      if (!VEC[i].wr)
        chk($sformatf("R%0d data vec %0d", VEC[i].req, i), rd_data, VEC[i].exp);
    end

    @(negedge clk);
    chk("R10 hold while idle", rd_data, 32'h10A24447);
    chk("R9 err drops after idle", {31'b0, err}, 32'h0);

    wr_en = 1'b1; wr_addr = 8'h84; wr_data = 32'h00000100;
    rd_en = 1'b1; rd_addr = 8'h8C;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    chk("R10 same-cycle read old", rd_data, 32'h1018101B);
    op(1'b0, 8'h80, 32'h0);
    chk("R10 write landed", rd_data, 32'h1018111B);

    op(1'b1, 8'h30, 32'h0);
    op(1'b0, 8'h30, 32'h0);
    chk("R7 lock cleared by software", rd_data, 32'h0);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    op(1'b0, 8'h30, 32'h0);
    chk("R7 lock restored by reset", rd_data, 32'h80013001);
    op(1'b0, 8'h94, 32'h0);
    chk("R1 plain restored by reset", rd_data, 32'h00000012);
    op(1'b0, 8'h84, 32'h0);
    chk("R1 group 8 restored by reset", rd_data, 32'h1018101B);

    finish_run();
  end
endmodule